// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external microcontroller read and write an 8-bit register file over a four-wire serial link. The link uses 8-bit frames that are chained together. While chip-select is low, the first frame carries a command: a 7-bit register address and a direction flag. The frame after it answers that command. After a read, that frame returns the register value, and the byte the master sends during it is taken as the next command. After a write, the byte the master sends is the value to store. The register storage is outside the block. The block reaches it through a parallel port: an address, a one-cycle write strobe with data, and a combinational read-data input.

All serial inputs are brought into the system clock domain with two-flop synchronizers. Edges of the serial clock are detected there. Received bits are captured on falling serial-clock edges, and outgoing bits are presented on rising edges. The serial data output comes with a separate enable, which the pad uses to float the line while chip-select is high. The value shifted out during the first frame of each transaction comes from a status input.

The control FSM has four states:
- ST_IDLE: chip-select is high.
- ST_ADDR: a command frame is expected.
- ST_RDATA: the frame after a read command.
- ST_WDATA: the frame after a write command.

Its transitions are:
- ST_IDLE to ST_ADDR when the synchronized chip-select goes low.
- ST_ADDR or ST_RDATA to ST_WDATA when a completed frame has bit 0 set.
- ST_ADDR or ST_RDATA to ST_RDATA when a completed frame has bit 0 clear.
- ST_WDATA to ST_ADDR when its frame completes.
- Any state to ST_IDLE when the synchronized chip-select is high.

Top module: `spi_reg_slave`

## Requirements
- R1: While chip-select is high (and during reset), `miso_oe` is 0 and no write strobe is issued; `miso_oe` is 1 while a transaction is active.
- R2: Every frame is 8 bits long, most significant bit first, on both `mosi` and `miso`.
- R3: A command frame carries the register address in bits [7:1] and the direction in bit [0], where 1 means write and 0 means read.
- R4: The first frame after chip-select falls shifts out the value of `status_in`.
- R5: The frame after a read command shifts out the addressed register's value, and the byte received in that frame is decoded as a new command.
- R6: The frame after a write command stores its received byte at the commanded address with a single one-cycle `reg_wr_en` pulse, and it shifts out the register's value from before the write.
- R7: The frame after a write data frame is a command frame, and it shifts out `status_in`.
- R8: If chip-select rises before 8 bits of a frame have been received, those bits are discarded, and no write results from them.
- R9: If chip-select rises right after a command frame, the pending access is dropped, and the next transaction starts with a command frame.
- R10: `mosi` is captured on falling serial-clock edges, and `miso` changes only after a rising serial-clock edge. Each serial-clock phase must last at least 4 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |
| status_in | input | 8 | Value returned during the first frame of a transaction |
| reg_addr | output | 7 | Register address for reads and writes |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Write data |
| reg_rd_data | input | 8 | Combinational read data for `reg_addr`; unimplemented bits must be 0 |

## Verification
The assertions assume the following about the master:
- Each serial-clock phase lasts at least four system clocks.
- `mosi` is stable around each falling edge.
- Chip-select goes low well before the first rising edge.
- Chip-select stays low until the last frame has been processed.
- `reg_rd_data` responds to `reg_addr` in the same cycle.

The bench master uses six system clocks per serial-clock phase and changes `mosi` only together with rising edges. It waits eight system clocks around each chip-select edge. Its register model answers combinationally, so every assertion premise holds throughout the stimulus.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
    localparam int FRAME_W = 8;
    localparam int ADDR_W  = 7;
    localparam int CNT_W   = $clog2(FRAME_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA
    } xfer_state_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift
    import spi_reg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               sclk_s,
    input  logic               mosi_s,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_val,
    output logic               sclk_rise,
    output logic               frame_done,
    output logic [FRAME_W-1:0] rx_byte,
    output logic               miso
);
    logic               sclk_prev;
    logic               sclk_fall;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] rx_sr;
    logic [FRAME_W-1:0] tx_sr;

    assign sclk_rise  = active && !sclk_prev && sclk_s;
    assign sclk_fall  = active && sclk_prev && !sclk_s;
    assign frame_done = sclk_fall && (bit_cnt == CNT_W'(FRAME_W - 1));
    assign rx_byte    = {rx_sr[FRAME_W-2:0], mosi_s};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            miso      <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
            if (!active) begin
                bit_cnt <= '0;
            end else if (sclk_fall) begin
                bit_cnt <= bit_cnt + 1'b1;
                rx_sr   <= rx_byte;
            end
            if (load) begin
                tx_sr <= load_val;
            end else if (sclk_rise) begin
                miso  <= tx_sr[FRAME_W-1];
                tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_reg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               mosi,
    output logic               miso,
    output logic               miso_oe,
    input  logic [FRAME_W-1:0] status_in,
    output logic [ADDR_W-1:0]  reg_addr,
    output logic               reg_wr_en,
    output logic [FRAME_W-1:0] reg_wr_data,
    input  logic [FRAME_W-1:0] reg_rd_data
);
    xfer_state_t        state, state_nx;
    logic               cs_s, sclk_s, mosi_s;
    logic               sclk_rise;
    logic               frame_done;
    logic [FRAME_W-1:0] rx_byte;
    logic               ld_q, ld_stat_q;

    spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, mosi}),
        .q     ({cs_s, sclk_s, mosi_s})
    );

    spi_frame_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (state != ST_IDLE),
        .sclk_s     (sclk_s),
        .mosi_s     (mosi_s),
        .load       (ld_q),
        .load_val   (ld_stat_q ? status_in : reg_rd_data),
        .sclk_rise  (sclk_rise),
        .frame_done (frame_done),
        .rx_byte    (rx_byte),
        .miso       (miso)
    );

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (!cs_s) state_nx = ST_ADDR;
            ST_ADDR, ST_RDATA: begin
                if (cs_s)            state_nx = ST_IDLE;
                else if (frame_done) state_nx = rx_byte[0] ? ST_WDATA : ST_RDATA;
            end
            ST_WDATA: begin
                if (cs_s)            state_nx = ST_IDLE;
                else if (frame_done) state_nx = ST_ADDR;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Registered outputs and load requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q        <= 1'b0;
            ld_stat_q   <= 1'b1;
            reg_addr    <= '0;
            reg_wr_en   <= 1'b0;
            reg_wr_data <= '0;
            miso_oe     <= 1'b0;
        end else begin
            ld_q      <= 1'b0;
            reg_wr_en <= 1'b0;
            miso_oe   <= (state_nx != ST_IDLE);
            unique case (state)
                ST_IDLE: if (!cs_s) begin
                    ld_q      <= 1'b1;
                    ld_stat_q <= 1'b1;
                end
                ST_ADDR, ST_RDATA: if (!cs_s && frame_done) begin
                    reg_addr  <= rx_byte[FRAME_W-1:1];
                    ld_q      <= 1'b1;
                    ld_stat_q <= 1'b0;
                end
                ST_WDATA: if (!cs_s && frame_done) begin
                    reg_wr_en   <= 1'b1;
                    reg_wr_data <= rx_byte;
                    ld_q        <= 1'b1;
                    ld_stat_q   <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic miso,
    input logic miso_oe,
    input logic reg_wr_en,
    input logic [6:0] reg_addr,
    input logic sclk_rise,
    input logic frame_done
);
    p_wr_when_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> miso_oe);

    p_wr_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    p_wr_addr_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $stable(reg_addr));

    p_wr_full_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $past(frame_done));

    p_miso_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sclk_rise) |-> $stable(miso));
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miso       (miso),
    .miso_oe    (miso_oe),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .sclk_rise  (sclk_rise),
    .frame_done (frame_done)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       miso, miso_oe;
    logic [7:0] status_in = 8'h80;
    logic [6:0] reg_addr;
    logic       reg_wr_en;
    logic [7:0] reg_wr_data;
    logic [7:0] reg_rd_data;
    logic [7:0] mem [128];
    int         n_chk = 0, n_fail = 0, n_wr = 0;
    logic [7:0] r0, r1;

    always #5 clk = ~clk;

    spi_reg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .status_in(status_in),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
    );

    // Register file model
    assign reg_rd_data = mem[reg_addr];
    always @(posedge clk) begin
        if (reg_wr_en) begin
            mem[reg_addr] <= reg_wr_data;
            n_wr++;
        end
    end

    // {command, data, expected resp0, expected resp1}
    localparam logic [31:0] VEC [6] = '{
        32'h0B_3C_80_00,   // write 0x05 <- 3C
        32'h0A_00_80_3C,   // read 0x05
        32'h0B_A1_80_3C,   // write 0x05 <- A1, old 3C returned
        32'h0A_00_80_A1,   // read 0x05
        32'hFF_FF_80_00,   // write 0x7F <- FF
        32'hFE_00_80_FF    // read 0x7F
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cs_low();
        @(negedge clk) cs_n = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic shift(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            sclk = 1'b1;
            mosi = tx[i];
            repeat (6) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b0;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] v);
        logic [7:0] t;
        cs_low();
        shift({a, 1'b0}, 8, t);
        shift(8'h00, 8, v);
        cs_high();
    endtask

    initial begin
        for (int a = 0; a < 128; a++) mem[a] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 reset oe", {7'd0, miso_oe}, 8'h00);
        chk("R1 reset wr", {7'd0, reg_wr_en}, 8'h00);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Vector table: R2 R3 R4 R5 R6 R10
        for (int k = 0; k < 6; k++) begin
            cs_low();
            chk("R1 oe active", {7'd0, miso_oe}, 8'h01);
            shift(VEC[k][31:24], 8, r0);
            shift(VEC[k][23:16], 8, r1);
            cs_high();
            chk("R4 first frame status", r0, VEC[k][15:8]);
            chk("R5/R6 second frame", r1, VEC[k][7:0]);
        end
        chk("R1 idle oe", {7'd0, miso_oe}, 8'h00);
        chk("R6 write pulse count", n_wr[7:0], 8'd3);

        // Chained sequence: read 05, write 05 <- 55, read 7F (R5 R7)
        cs_low();
        shift(8'h0A, 8, r0); chk("R4 chain status", r0, 8'h80);
        shift(8'h0B, 8, r0); chk("R5 chain read data", r0, 8'hA1);
        shift(8'h55, 8, r0); chk("R6 chain pre-write", r0, 8'hA1);
        shift(8'hFE, 8, r0); chk("R7 status after write", r0, 8'h80);
        shift(8'h00, 8, r0); chk("R5 chain read 7F", r0, 8'hFF);
        cs_high();
        rd(7'h05, r0);
        chk("R5 chained write landed", r0, 8'h55);
        chk("R6 chain pulse count", n_wr[7:0], 8'd5 - 8'd1);

        // Partial data frame discarded (R8)
        cs_low();
        shift(8'h0B, 8, r0);
        shift(8'h12, 5, r1);
        cs_high();
        chk("R8 no write from partial", n_wr[7:0], 8'd4);
        rd(7'h05, r0);
        chk("R8 register unchanged", r0, 8'h55);

        // Cancel after command frame (R9)
        cs_low();
        shift(8'h0B, 8, r0);
        cs_high();
        chk("R9 cancelled write", n_wr[7:0], 8'd4);
        cs_low();
        shift(8'h0A, 8, r0);
        shift(8'h00, 8, r1);
        cs_high();
        chk("R9 restart with status", r0, 8'h80);
        chk("R9 restart read", r1, 8'h55);

        // Status value follows input (R4)
        status_in = 8'h3C;
        rd(7'h7F, r1);
        cs_low();
        shift(8'h00, 8, r0);
        cs_high();
        chk("R4 new status", r0, 8'h3C);
        chk("R5 read after status change", r1, 8'hFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule